// File: doc/BRIEF.md
# Status-Reporting I2C Bus Master

This block is an I2C bus master steered byte by byte through a handful of registers. Software writes a data byte and a control byte. The block runs one bus step, which can be a START, a byte with its acknowledge bit, or a STOP. When the step completes, the block posts an eight-bit status code and raises an interrupt flag. While the flag is up, the block keeps SCL pulled low. The next step starts only when software writes the control register with the flag bit at zero. The start, stop and acknowledge-enable bits of that same write select what the step is.

The master can send an address with the direction in bit 0 and then continue as a transmitter or a receiver. It supports repeated START and STOP, and a STOP immediately followed by a START. It detects loss of arbitration while it has SDA released. It does not act as a slave, does not use 10-bit addresses and does not wait for a slave that stretches the clock. Both bus lines are open-drain: an output of 1 pulls the line low, and the line levels come back in on separate inputs.

Top module: `i2c_stat_master`

## Requirements
- R1: A START sent from idle sets the flag with status 08h. A START sent while the master still owns the bus (a repeated START) reports 10h.
- R2: An address byte whose bit 0 is 0 (write) reports 18h when acknowledged and 20h when not. With bit 0 at 1 (read), it reports 40h when acknowledged and 48h when not. The byte is sent MSB first.
- R3: In transmitter mode each data byte goes out MSB first. The status is 28h when the slave pulls SDA low in the ninth bit and 30h when it does not. SDA changes only while SCL is low.
- R4: In receiver mode a byte is shifted in MSB first and placed in the data register. The ninth bit is driven low (ACK) when the acknowledge-enable bit is 1 and left high (NACK) when it is 0. The status is 50h after an ACK and 58h after a NACK.
- R5: While the flag is 1 and arbitration has not been lost, SCL is held low and the bus does not move. A control write with bit 3 at 1 neither starts anything nor releases the flag. In idle, such a write does not set the flag.
- R6: The status reads F8h whenever the flag is 0, including just after reset.
- R7: Clearing the flag with stop=1 sends a STOP, after which both lines are released, the stop bit reads 0, and the flag stays 0. With start=1 and stop=1 together, the STOP is followed by a fresh START that reports 08h.
- R8: If the master leaves SDA released for a 1 and samples it low at the SCL high point, it reports 38h and releases both lines. Clearing the flag with start=0 returns it to idle with status F8h. Clearing it with start=1 sends a START (08h), but only once both lines are high.
- R9: Register map on `wr_sel`: 0 is data, 1 is control, 3 is the quarter-bit divider. The control bits are 5 = start, 4 = stop, 3 = flag, 2 = acknowledge-enable. One bit period is 4*(divider+1) clocks. The divider resets to 125, and the data and control registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| dat_q | output | 8 | Data register (received or loaded byte) |
| ctl_q | output | 8 | Control register |
| stat_q | output | 8 | Status code |
| irq | output | 1 | Interrupt flag |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest case to reach is arbitration loss. A second driver has to pull SDA low in the exact bit where this master sends a 1. After that, the bus must stay busy long enough to show that a restart request waits for a free bus. The bench includes an open-drain slave model that counts bits and bytes from the line edges. Attached to it is a rival driver that can be armed for one chosen byte and bit. The bench uses it once inside a data byte and once on the first address bit. For the address case it keeps the rival holding SDA low after start=1 is written and confirms that no START occurs until the rival lets go.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP, ST_HOLD} bus_st_t;

  localparam logic [7:0] CODE_START   = 8'h08;
  localparam logic [7:0] CODE_RSTART  = 8'h10;
  localparam logic [7:0] CODE_AW_ACK  = 8'h18;
  localparam logic [7:0] CODE_AW_NACK = 8'h20;
  localparam logic [7:0] CODE_TX_ACK  = 8'h28;
  localparam logic [7:0] CODE_TX_NACK = 8'h30;
  localparam logic [7:0] CODE_ARB     = 8'h38;
  localparam logic [7:0] CODE_AR_ACK  = 8'h40;
  localparam logic [7:0] CODE_AR_NACK = 8'h48;
  localparam logic [7:0] CODE_RX_ACK  = 8'h50;
  localparam logic [7:0] CODE_RX_NACK = 8'h58;
  localparam logic [7:0] CODE_IDLE    = 8'hF8;

  localparam int CB_STA = 5;
  localparam int CB_STO = 4;
  localparam int CB_SI  = 3;
  localparam int CB_AA  = 2;

  localparam logic [1:0] SEL_DAT = 2'd0;
  localparam logic [1:0] SEL_CTL = 2'd1;
  localparam logic [1:0] SEL_DIV = 2'd3;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_stat_master.sv
module i2c_stat_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 125,
  parameter int BITS    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] dat_q,
  output logic [7:0] ctl_q,
  output logic [7:0] stat_q,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       scl_in,
  input  logic       sda_in
);
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS);

  bus_st_t          st;
  logic [1:0]       ph;
  logic [CNT_W-1:0] bcnt;
  logic [7:0]       shreg;
  logic [DIV_W-1:0] div_q;
  logic             sta, sto, si, aa;
  logic             tx_mode, addr_phase, rw_q, in_txn, lost, ackbit;
  logic             tick, release_w, high_intent;
  logic [7:0]       done_code;

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (.clk(clk), .rst(rst), .div(div_q), .tick(tick));

  assign release_w = wr_en && (wr_sel == SEL_CTL) && !wr_data[CB_SI] && si;
  assign high_intent = (bcnt == LAST) ? !tx_mode : tx_mode;

  always_comb begin
    ctl_q = 8'h00;
    ctl_q[CB_STA] = sta;
    ctl_q[CB_STO] = sto;
    ctl_q[CB_SI]  = si;
    ctl_q[CB_AA]  = aa;
    irq = si;
    if (addr_phase)
      done_code = rw_q ? (ackbit ? CODE_AR_ACK : CODE_AR_NACK)
                       : (ackbit ? CODE_AW_ACK : CODE_AW_NACK);
    else if (tx_mode)
      done_code = ackbit ? CODE_TX_ACK : CODE_TX_NACK;
    else
      done_code = aa ? CODE_RX_ACK : CODE_RX_NACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ph <= '0; bcnt <= '0; shreg <= '0;
      dat_q <= '0; div_q <= DIV_W'(DIV_RST);
      sta <= 1'b0; sto <= 1'b0; si <= 1'b0; aa <= 1'b0;
      tx_mode <= 1'b0; addr_phase <= 1'b0; rw_q <= 1'b0;
      in_txn <= 1'b0; lost <= 1'b0; ackbit <= 1'b0;
      stat_q <= CODE_IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_DAT: dat_q <= wr_data;
          SEL_CTL: begin
            sta <= wr_data[CB_STA];
            sto <= wr_data[CB_STO];
            aa  <= wr_data[CB_AA];
            if (!wr_data[CB_SI]) begin
              si     <= 1'b0;
              stat_q <= CODE_IDLE;
            end
          end
          SEL_DIV: div_q <= wr_data[DIV_W-1:0];
          default: ;
        endcase
      end
      case (st)
        ST_IDLE: begin
          if (sta && scl_in && sda_in && tick) begin
            st <= ST_START;
            ph <= '0;
          end
        end
        ST_START: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe     <= 1'b1;
              si         <= 1'b1;
              stat_q     <= in_txn ? CODE_RSTART : CODE_START;
              in_txn     <= 1'b1;
              addr_phase <= 1'b1;
              st         <= ST_HOLD;
            end
          endcase
        end
        ST_HOLD: begin
          if (release_w) begin
            ph <= '0;
            if (lost) begin
              lost   <= 1'b0;
              in_txn <= 1'b0;
              st     <= ST_IDLE;
            end else if (wr_data[CB_STO]) begin
              st <= ST_STOP;
            end else if (wr_data[CB_STA]) begin
              st <= ST_START;
            end else begin
              st   <= ST_BIT;
              bcnt <= '0;
              if (addr_phase) begin
                shreg   <= dat_q;
                tx_mode <= 1'b1;
                rw_q    <= dat_q[0];
              end else begin
                shreg <= tx_mode ? dat_q : 8'h00;
              end
            end
          end
        end
        ST_BIT: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_oe <= (bcnt == LAST) ? (!tx_mode && aa) : (tx_mode && !shreg[7]);
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (!sda_oe && !sda_in && high_intent) begin
                lost   <= 1'b1;
                scl_oe <= 1'b0;
                sda_oe <= 1'b0;
                si     <= 1'b1;
                stat_q <= CODE_ARB;
                st     <= ST_HOLD;
              end else if (bcnt == LAST) begin
                ackbit <= !sda_in;
              end else if (!tx_mode) begin
                shreg <= {shreg[6:0], sda_in};
              end
            end
            default: begin
              scl_oe <= 1'b1;
              if (bcnt == LAST) begin
                si     <= 1'b1;
                stat_q <= done_code;
                st     <= ST_HOLD;
                if (addr_phase) begin
                  addr_phase <= 1'b0;
                  tx_mode    <= !rw_q;
                end else if (!tx_mode) begin
                  dat_q <= shreg;
                end
              end else begin
                bcnt <= bcnt + 1'b1;
                if (tx_mode) shreg <= {shreg[6:0], 1'b0};
              end
            end
          endcase
        end
        ST_STOP: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              sto    <= 1'b0;
              in_txn <= 1'b0;
              st     <= ST_IDLE;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: a posted event keeps the clock line pulled low
  assert_hold_low_R5: assert property (@(posedge clk) disable iff (rst)
    (si && !lost) |-> scl_oe);
  // R6: no pending event means the idle code
  assert_idle_code_R6: assert property (@(posedge clk) disable iff (rst)
    !si |-> (stat_q == CODE_IDLE));
  // R1: a newly raised flag always carries an event code
  assert_flag_code_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(si) |-> (stat_q != CODE_IDLE));
  // R3: no data edge while SCL is released inside a bit
  assert_sda_still_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BIT && $past(st) == ST_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
  // R8: after a lost arbitration both lines are let go
  assert_lost_release_R8: assert property (@(posedge clk) disable iff (rst)
    (si && lost) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/test_i2c_stat_master.sv
`timescale 1ns/1ps
module test_i2c_stat_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] dat_q, ctl_q, stat_q;
  logic irq, scl_oe, sda_oe;

  logic s_low = 1'b0, rival_hit = 1'b0, rival_en = 1'b0;
  int   rival_byte = 0, rival_bit = 0;
  wire  rival_low = rival_hit && rival_en;
  wire  scl_line = !scl_oe;
  wire  sda_line = !(sda_oe || s_low || rival_low);

  int total = 0, bad = 0;

  i2c_stat_master i_i2c_stat_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dat_q(dat_q), .ctl_q(ctl_q), .stat_q(stat_q), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_line), .sda_in(sda_line));

  always #10 clk = ~clk;

  // open-drain slave model
  logic       ack_addr = 1'b1;
  logic       ack_mem [32];
  logic [7:0] rd_mem [32];
  logic [7:0] got_mem [32];
  logic [7:0] got_addr = '0, sh = '0;
  logic       in_frame = 1'b0, rw = 1'b0, done = 1'b0;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  int         bp = 0, bno = 0, stop_cnt = 0;

  always @(scl_line or sda_line) begin
    if (scl_line && prev_scl && prev_sda && !sda_line) begin
      in_frame = 1'b1; bp = 0; bno = 0; done = 1'b0; s_low = 1'b0; rival_hit = 1'b0;
    end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
      in_frame = 1'b0; s_low = 1'b0; stop_cnt++;
    end else if (scl_line && !prev_scl && in_frame) begin
      if (bp < 8) sh = {sh[6:0], sda_line};
      if (bp == 7 && bno == 0) rw = sda_line;
      if (bp == 8) begin
        if (bno == 0) begin
          got_addr = sh;
          if (!ack_addr) done = 1'b1;
        end else if (!rw) got_mem[(bno-1) & 31] = sh;
        else if (sda_line) done = 1'b1;
        bp = 0; bno++;
      end else bp++;
    end else if (!scl_line && prev_scl && in_frame) begin
      s_low = 1'b0;
      if (bp == 8) begin
        if (bno == 0) s_low = ack_addr;
        else if (!rw && !done) s_low = ack_mem[(bno-1) & 31];
      end else if (rw && bno > 0 && !done)
        s_low = !rd_mem[(bno-1) & 31][7-bp];
      if (rival_en && bno == rival_byte && bp == rival_bit) rival_hit = 1'b1;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // SCL release spacing monitor
  int cyc = 0, t_last = 0, t_prev = 0;
  logic prev_oe = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (prev_oe && !scl_oe) begin t_prev = t_last; t_last = cyc; end
    prev_oe = scl_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input logic s, input logic p, input logic a);
    wr(2'd1, {2'b00, s, p, 1'b0, a, 2'b00});
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    if (!irq) begin
      total++; bad++;
      $display("FAIL %s actual=no-flag expected=flag", req);
    end
  endtask

  task automatic idle_for(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int tx_code(input logic a);
    return a ? 32'h28 : 32'h30;
  endfunction

  function automatic int rx_code(input logic a);
    return a ? 32'h50 : 32'h58;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin ack_mem[i] = 1'b1; rd_mem[i] = 8'($urandom); end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 reset status", stat_q, 8'hF8);
    chk("R9 reset control", ctl_q, 0);
    chk("R9 reset lines", {scl_oe, sda_oe, irq}, 0);
    wr(2'd3, 8'd3);

    // R5: a flag write of 1 in idle does nothing
    wr(2'd1, 8'h08);
    idle_for(100);
    chk("R5 idle flag write", {irq, scl_oe, sda_oe}, 0);

    ctl(1, 0, 0);
    wait_irq("R1 start");
    chk("R1 start code", stat_q, 8'h08);
    idle_for(200);
    chk("R5 SCL held", scl_oe, 1);
    wr(2'd1, 8'h08);
    idle_for(200);
    chk("R5 flag=1 write keeps hold", {irq, scl_oe}, 2'b11);
    chk("R5 code kept", stat_q, 8'h08);

    wr(2'd0, 8'hA0);
    ctl(0, 0, 0);
    wait_irq("R2 addr write");
    chk("R2 write addr ack", stat_q, 8'h18);
    chk("R2 addr bits", got_addr, 8'hA0);

    for (int i = 0; i < 8; i++) begin
      d = 8'($urandom);
      a = 1'($urandom);
      ack_mem[i] = a;
      wr(2'd0, d);
      ctl(0, 0, 0);
      wait_irq("R3 tx");
      chk("R3 tx code", stat_q, tx_code(a));
      chk("R3 tx byte", got_mem[i], d);
    end
    chk("R9 bit period", t_last - t_prev, 16);

    ctl(1, 0, 0);
    wait_irq("R1 rstart");
    chk("R1 repeated start", stat_q, 8'h10);
    wr(2'd0, 8'hA1);
    ctl(0, 0, 1);
    wait_irq("R2 addr read");
    chk("R2 read addr ack", stat_q, 8'h40);
    for (int j = 0; j < 6; j++) begin
      a = (j < 5);
      ctl(0, 0, a);
      wait_irq("R4 rx");
      chk("R4 rx code", stat_q, rx_code(a));
      chk("R4 rx byte", dat_q, rd_mem[j]);
    end
    ctl(0, 1, 0);
    idle_for(100);
    chk("R7 stop flag/code", {irq, stat_q}, {1'b0, 8'hF8});
    chk("R7 stop bit cleared", ctl_q[4], 0);
    chk("R7 lines free", {scl_oe, sda_oe, in_frame}, 0);

    ack_addr = 1'b0;
    ctl(1, 0, 0);
    wait_irq("R1 start2");
    chk("R1 start again", stat_q, 8'h08);
    wr(2'd0, 8'hA1);
    ctl(0, 0, 0);
    wait_irq("R2 read nack");
    chk("R2 read addr nack", stat_q, 8'h48);
    ack_addr = 1'b1;
    begin
      int sc;
      sc = stop_cnt;
      ctl(1, 1, 0);
      wait_irq("R7 stop+start");
      chk("R7 stop then start code", stat_q, 8'h08);
      chk("R7 stop seen", stop_cnt - sc, 1);
    end

    // R8: arbitration loss inside a data byte, then release to idle
    rival_byte = 1; rival_bit = 0; rival_en = 1'b1;
    wr(2'd0, 8'hA0);
    ctl(0, 0, 0);
    wait_irq("R2 addr");
    chk("R2 write addr ack 2", stat_q, 8'h18);
    wr(2'd0, 8'h80);
    ctl(0, 0, 0);
    wait_irq("R8 lost data");
    chk("R8 lost code", stat_q, 8'h38);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    rival_en = 1'b0;
    ctl(0, 0, 0);
    idle_for(300);
    chk("R8 back to idle", {irq, stat_q}, {1'b0, 8'hF8});
    chk("R8 idle lines", {scl_oe, sda_oe}, 0);

    // R8: loss on the first address bit, restart waits for a free bus
    rival_byte = 0; rival_bit = 0; rival_en = 1'b1;
    ctl(1, 0, 0);
    wait_irq("R1 start3");
    chk("R1 start3 code", stat_q, 8'h08);
    wr(2'd0, 8'hA1);
    ctl(0, 0, 0);
    wait_irq("R8 lost addr");
    chk("R8 lost addr code", stat_q, 8'h38);
    ctl(1, 0, 0);
    idle_for(200);
    chk("R8 waits for free bus", irq, 0);
    rival_en = 1'b0;
    wait_irq("R8 restart");
    chk("R8 restart code", stat_q, 8'h08);
    ctl(0, 1, 0);
    idle_for(100);
    chk("R7 final release", {irq, scl_oe, sda_oe}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule